// File: doc/BRIEF.md
# Dual 8-Bit Compare Timer with 16-Bit Chaining

This block holds two independent 8-bit up-counters. Each counter advances on a count enable that it picks from a shared prescaler or from its own external count pin. The prescaler divides the block clock by 1, 2, 8, 32, 64, 1024 or 8192, and the external pin is synchronised before its rising edges are counted. Each counter is compared against two byte registers. A match on the first register can restart the count, which sets the period. The first match drives the channel's waveform pin high and the second drives it low, so the pin carries a pulse train or a PWM signal. A match on the first register can also emit a one-cycle pulse that starts a data converter, and the waveform pin can serve as a bit-rate clock for a serial port.

A chaining bit joins the two counters into one 16-bit counter. In that mode channel 1 is the low byte and runs from its own clock choice. Channel 0 is the high byte and steps each time channel 1 wraps. Both compare registers of each channel are then joined, with channel 0 as the high byte. A small write/read register port configures the block and clears its sticky event flags.

Top module: `tmr_dual`

## Requirements
- R1: After reset every counter, control register, status register, waveform pin and trigger pin reads 0, and every compare register reads 0xFF.
- R2: Clock-select codes 0 to 6 (control bits [2:0]) make a counter advance once every 1, 2, 8, 32, 64, 1024 or 8192 clock cycles respectively, so it advances exactly M times in M×N cycles.
- R3: Clock-select code 7 counts rising edges of the channel's external pin after a two-flop synchroniser, one count per edge, with the count visible three clock edges after the pin rises.
- R4: On a count step where the counter equals compare A, status bit 0 sets. If control bit 3 is set the counter returns to 0 instead of stepping, so the count runs 0 to A.
- R5: A compare-A match drives the waveform pin high and a compare-B match (status bit 1) drives it low; when both match on the same step the pin goes high.
- R6: When control bit 4 is set, each compare-A match raises the channel's converter trigger for exactly one cycle.
- R7: A step from 0xFF to 0x00 sets status bit 2; a restart from a compare-A match does not.
- R8: Status bits stay set until the host writes 1 to them; a written 0 leaves them alone, and a flag being set wins over a clear in the same cycle.
- R9: With control bit 5 of channel 0 set, channel 0 steps once per channel 1 wrap, the 16-bit value {cnt0,cnt1} is compared with {A0,A1} and {B0,B1}, and those matches drive channel 0's flags, pin and trigger while channel 1's compare flags stay clear.
- R10: A host write to a counter takes effect on that edge and overrides any step, restart or carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Bit 3 = channel; bits [2:0]: 0 control, 1 counter, 2 compare A, 3 compare B, 4 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ext_clk_i | input | 2 | External count pin per channel |
| wave_o | output | 2 | Waveform pin per channel |
| adc_trig_o | output | 2 | Converter start pulse per channel |

## Verification
Counter writes, steps, flags, the waveform pin and the trigger all register on the edge that sees the event, so each of them is due one edge after the counter value that caused it is on the port. The bench counts edges from a known write edge and samples one time step after the edge it expects. External counts are due three edges after the pin rises, and the bench waits well past that before it reads. Prescaled runs are read after exactly M×N edges. That window holds M enables whatever phase the shared divider is in.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CW     = 8;
    localparam int NCH    = 2;
    localparam int NSEL   = 7;
    localparam int SEL_W  = 3;
    localparam int ST_W   = 3;
    localparam int ST_A   = 0;
    localparam int ST_B   = 1;
    localparam int ST_OVF = 2;

    localparam logic [2:0] OFF_CTRL = 3'd0;
    localparam logic [2:0] OFF_CNT  = 3'd1;
    localparam logic [2:0] OFF_CMPA = 3'd2;
    localparam logic [2:0] OFF_CMPB = 3'd3;
    localparam logic [2:0] OFF_STAT = 3'd4;

    // Divider tap width for each clock-select code.
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 3;
            3:       return 5;
            4:       return 6;
            5:       return 10;
            default: return 13;
        endcase
    endfunction

    localparam int DIV_W = tap_shift(NSEL - 1);

    typedef struct packed {
        logic             chain;
        logic             trig_en;
        logic             clr_a;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   cmpa;
        logic [CW-1:0]   cmpb;
        ctrl_t           ctrl;
        logic [ST_W-1:0] stat;
        logic            wave;
        logic            trig;
    } chan_t;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider
    import tmr_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    output logic [NSEL-1:0] tap_o
);
    logic [DW-1:0] div_d, div_q;

    always_comb div_d = div_q + 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    for (genvar i = 0; i < NSEL; i++) begin : g_tap
        localparam int K = tap_shift(i);
        if (K == 0) begin : g_full
            assign tap_o[i] = 1'b1;
        end else begin : g_div
            assign tap_o[i] = &div_q[K-1:0];
        end
    end

    // R2
    half_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_o[1] |=> !tap_o[1]);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_i,
    output logic rise_o
);
    logic [2:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[1:0], ext_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rise_o = sh_q[1] & ~sh_q[2];

    // R3
    single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
    import tmr_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_en_i,
    input  logic [3:0]     addr_i,
    input  logic [CW-1:0]  wdata_i,
    output logic [CW-1:0]  rdata_o,
    input  logic [NCH-1:0] ext_clk_i,
    output logic [NCH-1:0] wave_o,
    output logic [NCH-1:0] adc_trig_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    chan_t [NCH-1:0] s_d, s_q;

    logic [NSEL-1:0]   tap;
    logic [NCH-1:0]    ext_rise, tick, wr_cnt, hit_a, hit_b, clr, adv, wrap;
    logic              chain;
    logic [2*CW-1:0]   cnt16, cmpa16, cmpb16;
    logic [NSEL:0]     sel_src [NCH];

    tmr_divider u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tap_o  (tap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ext
        tmr_edge_sync u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .ext_i  (ext_clk_i[c]),
            .rise_o (ext_rise[c])
        );
    end

    // Count enables and compare events
    always_comb begin
        chain  = s_q[0].ctrl.chain;
        cnt16  = {s_q[0].cnt,  s_q[1].cnt};
        cmpa16 = {s_q[0].cmpa, s_q[1].cmpa};
        cmpb16 = {s_q[0].cmpb, s_q[1].cmpb};
        for (int c = 0; c < NCH; c++) begin
            sel_src[c] = {ext_rise[c], tap};
            tick[c]    = sel_src[c][s_q[c].ctrl.sel];
            wr_cnt[c]  = wr_en_i && (addr_i[3] == 1'(c)) && (addr_i[2:0] == OFF_CNT);
        end
        hit_a[1] = !chain && tick[1] && (s_q[1].cnt == s_q[1].cmpa);
        hit_b[1] = !chain && tick[1] && (s_q[1].cnt == s_q[1].cmpb);
        if (chain) begin
            hit_a[0] = tick[1] && (cnt16 == cmpa16);
            hit_b[0] = tick[1] && (cnt16 == cmpb16);
        end else begin
            hit_a[0] = tick[0] && (s_q[0].cnt == s_q[0].cmpa);
            hit_b[0] = tick[0] && (s_q[0].cnt == s_q[0].cmpb);
        end
        clr[0]  = hit_a[0] && s_q[0].ctrl.clr_a;
        clr[1]  = chain ? clr[0] : (hit_a[1] && s_q[1].ctrl.clr_a);
        adv[1]  = tick[1];
        wrap[1] = adv[1] && (s_q[1].cnt == CNT_MAX) && !clr[1] && !wr_cnt[1];
        adv[0]  = chain ? wrap[1] : tick[0];
        wrap[0] = adv[0] && (s_q[0].cnt == CNT_MAX) && !clr[0] && !wr_cnt[0];
    end

    // Next state
    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NCH; c++) begin
            s_d[c].trig = hit_a[c] && s_q[c].ctrl.trig_en;
            if (hit_a[c])      s_d[c].wave = 1'b1;
            else if (hit_b[c]) s_d[c].wave = 1'b0;

            if (wr_cnt[c])   s_d[c].cnt = wdata_i;
            else if (clr[c]) s_d[c].cnt = '0;
            else if (adv[c]) s_d[c].cnt = s_q[c].cnt + 1'b1;

            if (wr_en_i && (addr_i[3] == 1'(c))) begin
                case (addr_i[2:0])
                    OFF_CTRL: s_d[c].ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
                    OFF_CMPA: s_d[c].cmpa = wdata_i;
                    OFF_CMPB: s_d[c].cmpb = wdata_i;
                    OFF_STAT: s_d[c].stat = s_q[c].stat & ~wdata_i[ST_W-1:0];
                    default:  ;
                endcase
            end
            if (hit_a[c]) s_d[c].stat[ST_A]   = 1'b1;
            if (hit_b[c]) s_d[c].stat[ST_B]   = 1'b1;
            if (wrap[c])  s_d[c].stat[ST_OVF] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int c = 0; c < NCH; c++) begin
                s_q[c]      <= '0;
                s_q[c].cmpa <= '1;
                s_q[c].cmpb <= '1;
            end
        end else begin
            s_q <= s_d;
        end
    end

    // Register read
    always_comb begin
        rdata_o = '0;
        case (addr_i[2:0])
            OFF_CTRL: rdata_o[CTRL_W-1:0] = s_q[addr_i[3]].ctrl;
            OFF_CNT:  rdata_o = s_q[addr_i[3]].cnt;
            OFF_CMPA: rdata_o = s_q[addr_i[3]].cmpa;
            OFF_CMPB: rdata_o = s_q[addr_i[3]].cmpb;
            OFF_STAT: rdata_o[ST_W-1:0] = s_q[addr_i[3]].stat;
            default:  rdata_o = '0;
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign wave_o[c]     = s_q[c].wave;
        assign adc_trig_o[c] = s_q[c].trig;
    end

    // R8
    sticky_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(s_q[1].stat[ST_OVF]) |->
            $past(wr_en_i && addr_i == {1'b1, OFF_STAT} && wdata_i[ST_OVF]));

    // R6
    trig_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_trig_o[0] |-> s_q[0].stat[ST_A]);

    // R9
    chain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chain && !wr_en_i && !s_q[0].ctrl.clr_a && s_q[1].cnt != CNT_MAX)
            |=> $stable(s_q[0].cnt));

    // R4
    period_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!chain && s_q[1].ctrl.clr_a && s_q[1].cnt <= s_q[1].cmpa && !wr_en_i)
            |=> (s_q[1].cnt <= s_q[1].cmpa));

    // R5
    wave_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!chain && $rose(wave_o[1])) |-> $past(s_q[1].cnt == s_q[1].cmpa));
endmodule

// File: tb/tmr_dual_tb.sv
module tmr_dual_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;
    localparam int NROW = 7;
    localparam int ROW_SEL [NROW] = '{0, 1, 2, 3, 4, 5, 6};
    localparam int ROW_DIV [NROW] = '{1, 2, 8, 32, 64, 1024, 8192};
    localparam int ROW_M   [NROW] = '{20, 10, 6, 4, 3, 3, 2};

    localparam logic [3:0] C0_CTRL = 4'h0, C0_CNT = 4'h1, C0_CMPA = 4'h2, C0_CMPB = 4'h3, C0_STAT = 4'h4;
    localparam logic [3:0] C1_CTRL = 4'h8, C1_CNT = 4'h9, C1_CMPA = 4'hA, C1_CMPB = 4'hB, C1_STAT = 4'hC;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic [1:0] ext_clk_i = '0;
    logic [1:0] wave_o, adc_trig_o;

    int n_chk = 0;
    int n_bad = 0;

    tmr_dual u_dut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .ext_clk_i  (ext_clk_i),
        .wave_o     (wave_o),
        .adc_trig_o (adc_trig_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
        addr_i = a;
        #1;
        chk(tag, rdata_o, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(posedge clk_i);
        #1;
        wr_en_i = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk_i);
        #1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk_i);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset values, sampled while reset is held
        step(3);
        rd("R1 ctrl0", C0_CTRL, 8'h00);
        rd("R1 cnt0",  C0_CNT,  8'h00);
        rd("R1 cmpa0", C0_CMPA, 8'hFF);
        rd("R1 cmpb1", C1_CMPB, 8'hFF);
        rd("R1 stat0", C0_STAT, 8'h00);
        chk("R1 wave", {6'b0, wave_o}, 8'h00);
        chk("R1 trig", {6'b0, adc_trig_o}, 8'h00);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R2 table walk: M steps in M*N cycles for each prescale code
        for (int r = 0; r < NROW; r++) begin
            wr(C0_CTRL, 8'(ROW_SEL[r]));
            wr(C0_CNT, 8'h00);
            step(ROW_M[r] * ROW_DIV[r]);
            rd($sformatf("R2 sel=%0d", ROW_SEL[r]), C0_CNT, 8'(ROW_M[r]));
        end

        // R4 R5 R6 R10 on channel 1: A=5 restart+trigger, B=2
        wr(C1_CMPA, 8'd5);
        wr(C1_CMPB, 8'd2);
        wr(C1_CTRL, 8'h18);
        wr(C1_CNT, 8'h00);
        rd("R10 write wins over step", C1_CNT, 8'h00);
        wr(C1_STAT, 8'h07);
        step(2);
        chk("R5 B match low", {7'b0, wave_o[1]}, 8'd0);
        rd("R5 B flag", C1_STAT, 8'h02);
        step(3);
        chk("R5 A match high", {7'b0, wave_o[1]}, 8'd1);
        chk("R6 trig pulse", {7'b0, adc_trig_o[1]}, 8'd1);
        rd("R4 restart", C1_CNT, 8'h00);
        rd("R4 A flag", C1_STAT, 8'h03);
        step(1);
        chk("R6 trig one cycle", {7'b0, adc_trig_o[1]}, 8'd0);
        rd("R4 count after restart", C1_CNT, 8'h01);
        step(2);
        chk("R5 low again", {7'b0, wave_o[1]}, 8'd0);
        wr(C1_CMPB, 8'd5);
        wr(C1_CNT, 8'h00);
        step(5);
        chk("R5 before tie", {7'b0, wave_o[1]}, 8'd0);
        step(1);
        chk("R5 tie goes high", {7'b0, wave_o[1]}, 8'd1);
        chk("R6 trig on tie", {7'b0, adc_trig_o[1]}, 8'd1);

        // R7 wrap sets overflow
        wr(C1_CTRL, 8'h00);
        wr(C1_CNT, 8'hFE);
        wr(C1_STAT, 8'h07);
        rd("R7 no wrap yet", C1_STAT, 8'h00);
        step(1);
        rd("R7 wrap flag", C1_STAT, 8'h04);
        rd("R7 wrapped count", C1_CNT, 8'h00);

        // R7 restart at 0xFF is not an overflow
        wr(C1_CMPA, 8'hFF);
        wr(C1_CTRL, 8'h08);
        wr(C1_CNT, 8'hFD);
        wr(C1_STAT, 8'h07);
        step(2);
        rd("R7 restart count", C1_CNT, 8'h00);
        rd("R7 restart no ovf", C1_STAT, 8'h01);

        // R8 write-one-to-clear and set priority
        wr(C1_CNT, 8'h80);
        wr(C1_STAT, 8'h00);
        rd("R8 zero write keeps", C1_STAT, 8'h01);
        wr(C1_STAT, 8'h01);
        rd("R8 one write clears", C1_STAT, 8'h00);
        wr(C1_CMPA, 8'd3);
        wr(C1_CNT, 8'h00);
        step(3);
        rd("R8 still clear", C1_STAT, 8'h00);
        wr(C1_STAT, 8'h01);
        rd("R8 set beats clear", C1_STAT, 8'h01);

        // R3 external count pin on channel 1
        wr(C1_CTRL, 8'h07);
        wr(C1_CNT, 8'h00);
        step(4);
        rd("R3 idle pin", C1_CNT, 8'h00);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk_i);
            ext_clk_i[1] = 1'b1;
            repeat (3) @(negedge clk_i);
            ext_clk_i[1] = 1'b0;
            repeat (2) @(negedge clk_i);
        end
        step(4);
        rd("R3 five edges", C1_CNT, 8'd5);

        // R9 chaining: {cnt0,cnt1}, compare A = 0x1305
        wr(C1_CTRL, 8'h00);
        wr(C1_CNT, 8'h00);
        wr(C0_CMPA, 8'h13);
        wr(C1_CMPA, 8'h05);
        wr(C0_CTRL, 8'h20);
        wr(C0_STAT, 8'h07);
        wr(C1_STAT, 8'h07);
        wr(C0_CNT, 8'h12);
        wr(C1_CNT, 8'hFE);
        rd("R9 high byte loaded", C0_CNT, 8'h12);
        step(1);
        rd("R9 no carry yet", C0_CNT, 8'h12);
        step(1);
        rd("R9 carry into high", C0_CNT, 8'h13);
        rd("R9 low wrapped", C1_CNT, 8'h00);
        step(5);
        rd("R9 no match yet", C0_STAT, 8'h00);
        step(1);
        rd("R9 16-bit match flag", C0_STAT, 8'h01);
        chk("R9 pin from 16-bit match", {7'b0, wave_o[0]}, 8'd1);
        rd("R9 low byte flags", C1_STAT, 8'h04);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule